// File: doc/BRIEF.md
# Serial Channel Control and Status Register Block

This block keeps the control and status state of a single serial channel and exposes it on a byte-wide register bus. A write to the command location can switch the receiver and transmitter on or off and, in the same cycle, run one encoded housekeeping command: rewind the mode-register pointer, reset the receiver, reset the transmitter, clear the error flags or clear the break-change interrupt. Command codes for break generation, modem-line control and receive timeout are accepted and have no effect, because the shifters and line drivers live elsewhere.

The block presents an 8-bit status register built from its own transmitter state, the receive FIFO's occupancy inputs and sticky error flags fed by event pulses from the receive path. Two mode registers share one address and are reached through a pointer that advances after every access and then stays on the last register. A byte written to the transmit holding location is passed out as a one-cycle strobe, but only while the transmitter is ready. Three level flags (transmitter ready, receiver ready, break change) go to the interrupt logic.

Top module: `uart_chctl`

## Requirements
- R1: Command bit 0 switches the receiver on and command bit 1 switches it off; when both are set in one write the receiver ends up off. `rx_en` shows the result from the cycle after the write.
- R2: Command bit 2 sets status TXRDY (bit 2), status TXEMT (bit 3) and `irq_txrdy`; command bit 3 clears all three; with both bits set they end up clear.
- R3: Command bits 7:4 hold an encoded command run after the low-nibble bits in the same write: code 3 (transmitter reset) clears TXRDY, TXEMT and `irq_txrdy` even when bit 2 is set; codes 0 and 6 to 15 other than the five listed change no status bit, no interrupt flag, neither `rx_en` nor the mode pointer.
- R4: Code 2 (receiver reset) switches the receiver off even with bit 0 set, pulses `fifo_flush` during the write cycle, and clears RXRDY (bit 0), FFULL (bit 1) and `irq_rxrdy` on the next cycle.
- R5: Pulses on `err_evt` set the sticky status flags overrun (bit 4, `err_evt[0]`), parity (bit 5, `err_evt[1]`), framing (bit 6, `err_evt[2]`) and break (bit 7, `err_evt[3]`); code 4 clears bits 7:4 and leaves bits 3:0 and `irq_brk` unchanged.
- R6: A break event raises `irq_brk` only when status bit 7 is clear at that moment; code 5 clears `irq_brk` without touching the status register.
- R7: An access (read or write) at the mode address (0) reaches the mode register selected by the pointer and then moves the pointer to the second register, where it stays; only code 1 moves it back to the first. Both mode registers and the pointer are 0 after reset.
- R8: A write to the holding address (3) while TXRDY is set produces `tx_valid` for exactly one cycle with the written byte on `tx_data`, on the cycle after the write, and leaves TXRDY set; while TXRDY is clear the byte is dropped and `tx_valid` stays low.
- R9: The address map is 0 mode, 1 status (reads; writes are ignored), 2 command (write), 3 transmit holding (write). After reset the status register reads 0, `rx_en` and all interrupt flags are 0.
- R10: Status RXRDY and FFULL follow the `rx_nonempty` and `rx_full` inputs one cycle later, and `irq_rxrdy` equals RXRDY.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the addressed register |
| rx_nonempty | input | 1 | Receive FIFO holds at least one byte |
| rx_full | input | 1 | Receive FIFO is full |
| err_evt | input | 4 | Error event pulses: break, framing, parity, overrun (msb to lsb) |
| rx_en | output | 1 | Receiver enable |
| fifo_flush | output | 1 | Empties the receive FIFO at the current edge |
| tx_valid | output | 1 | One-cycle strobe for a byte to transmit |
| tx_data | output | 8 | Byte to transmit |
| irq_txrdy | output | 1 | Transmitter-ready interrupt flag |
| irq_rxrdy | output | 1 | Receiver-ready interrupt flag |
| irq_brk | output | 1 | Break-change interrupt flag |

## Verification
On every cycle the assertions check that a disable bit or a reset command leaves the receiver or transmitter off in the following cycle, that an enable alone turns on both transmitter status bits and the interrupt flag, that an error-clear without a concurrent event empties the upper status nibble, that a mode access moves the pointer off the first register, and that no byte leaves without TXRDY. Only the scenarios can show the contents read back through the shared mode address, the order of the transmitted bytes, the break-interrupt rule that depends on the prior status bit, and that the ignored command codes and status-address writes leave every observable bit as it was.

// File: rtl/uart_chctl_pkg.sv
package uart_chctl_pkg;

   localparam int STAT_W = 8;

   // encoded command codes, upper nibble of the command byte
   localparam logic [3:0] OP_NONE    = 4'd0;
   localparam logic [3:0] OP_PTR_CLR = 4'd1;
   localparam logic [3:0] OP_RX_RST  = 4'd2;
   localparam logic [3:0] OP_TX_RST  = 4'd3;
   localparam logic [3:0] OP_ERR_CLR = 4'd4;
   localparam logic [3:0] OP_BRK_CLR = 4'd5;

   // status register bit positions
   localparam int SB_RXRDY = 0;
   localparam int SB_FFULL = 1;
   localparam int SB_TXRDY = 2;
   localparam int SB_TXEMT = 3;
   localparam int SB_ERR_LO = 4;

   typedef struct packed {
      logic rx_on;
      logic rx_off;
      logic tx_on;
      logic tx_off;
      logic ptr_clr;
      logic rx_rst;
      logic tx_rst;
      logic err_clr;
      logic brk_clr;
   } chctl_cmd_t;

endpackage

// File: rtl/chctl_cmd_decode.sv
module chctl_cmd_decode
   import uart_chctl_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          cmd_wr,
   input  logic [DW-1:0] cmd_byte,
   output chctl_cmd_t    ctl
);
   localparam int LO_W = 4;

   logic [LO_W-1:0] lo_bits;
   logic [3:0]      op;

   assign lo_bits = cmd_byte[LO_W-1:0];
   assign op      = cmd_byte[7:4];

   always_comb begin
      ctl = '0;
      if (cmd_wr) begin
         ctl.rx_on  = lo_bits[0];
         ctl.rx_off = lo_bits[1];
         ctl.tx_on  = lo_bits[2];
         ctl.tx_off = lo_bits[3];
         unique case (op)
            OP_PTR_CLR: ctl.ptr_clr = 1'b1;
            OP_RX_RST:  ctl.rx_rst  = 1'b1;
            OP_TX_RST:  ctl.tx_rst  = 1'b1;
            OP_ERR_CLR: ctl.err_clr = 1'b1;
            OP_BRK_CLR: ctl.brk_clr = 1'b1;
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/chctl_mode_regs.sv
module chctl_mode_regs #(
   parameter int DW     = 8,
   parameter int N_MODE = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_rd,
   input  logic          acc_wr,
   input  logic [DW-1:0] wdata,
   input  logic          ptr_clr,
   output logic [DW-1:0] rdata
);
   localparam int PW = (N_MODE > 1) ? $clog2(N_MODE) : 1;
   localparam logic [PW-1:0] PTR_LAST = PW'(N_MODE - 1);

   logic [PW-1:0] ptr_q;
   logic [DW-1:0] regs_q [N_MODE];

   generate
      if (N_MODE < 2) begin : g_bad_depth
         $error("chctl_mode_regs needs at least two mode registers");
      end
      for (genvar gi = 0; gi < N_MODE; gi++) begin : g_mreg
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs_q[gi] <= '0;
            else if (acc_wr && ptr_q == PW'(gi))
               regs_q[gi] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (ptr_clr)
         ptr_q <= '0;
      else if ((acc_rd || acc_wr) && ptr_q != PTR_LAST)
         ptr_q <= ptr_q + 1'b1;
   end

   assign rdata = regs_q[ptr_q];

   AST_PTR_LEAVES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_rd || acc_wr) && !ptr_clr) |=> (ptr_q != '0)); // R7
endmodule

// File: rtl/chctl_status_core.sv
module chctl_status_core
   import uart_chctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  chctl_cmd_t        ctl,
   input  logic              rx_nonempty,
   input  logic              rx_full,
   input  logic [3:0]        err_evt,
   output logic [STAT_W-1:0] status,
   output logic              rx_en,
   output logic              tx_rdy,
   output logic              irq_txrdy,
   output logic              irq_rxrdy,
   output logic              irq_brk
);
   localparam int N_ERR = STAT_W - SB_ERR_LO;

   logic             rx_en_q;
   logic             txrdy_q, txemt_q, irq_tx_q;
   logic             rxrdy_q, ffull_q;
   logic [N_ERR-1:0] err_q;
   logic             brk_irq_q;

   // receiver enable: enable first, then disable, then encoded reset
   always_ff @(posedge clk) begin
      if (!rst_n)
         rx_en_q <= 1'b0;
      else if (ctl.rx_off || ctl.rx_rst)
         rx_en_q <= 1'b0;
      else if (ctl.rx_on)
         rx_en_q <= 1'b1;
   end

   // transmitter state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         txrdy_q  <= 1'b0;
         txemt_q  <= 1'b0;
         irq_tx_q <= 1'b0;
      end else if (ctl.tx_off || ctl.tx_rst) begin
         txrdy_q  <= 1'b0;
         txemt_q  <= 1'b0;
         irq_tx_q <= 1'b0;
      end else if (ctl.tx_on) begin
         txrdy_q  <= 1'b1;
         txemt_q  <= 1'b1;
         irq_tx_q <= 1'b1;
      end
   end

   // receive FIFO occupancy mirror
   always_ff @(posedge clk) begin
      if (!rst_n || ctl.rx_rst) begin
         rxrdy_q <= 1'b0;
         ffull_q <= 1'b0;
      end else begin
         rxrdy_q <= rx_nonempty;
         ffull_q <= rx_full;
      end
   end

   // sticky error flags: a new event wins over a clear in the same cycle
   generate
      for (genvar ge = 0; ge < N_ERR; ge++) begin : g_err
         always_ff @(posedge clk) begin
            if (!rst_n)
               err_q[ge] <= 1'b0;
            else if (err_evt[ge])
               err_q[ge] <= 1'b1;
            else if (ctl.err_clr)
               err_q[ge] <= 1'b0;
         end
      end
   endgenerate

   // break-change interrupt: raised only on a break not already flagged
   always_ff @(posedge clk) begin
      if (!rst_n)
         brk_irq_q <= 1'b0;
      else if (err_evt[N_ERR-1] && !err_q[N_ERR-1])
         brk_irq_q <= 1'b1;
      else if (ctl.brk_clr)
         brk_irq_q <= 1'b0;
   end

   always_comb begin
      status                          = '0;
      status[SB_RXRDY]                = rxrdy_q;
      status[SB_FFULL]                = ffull_q;
      status[SB_TXRDY]                = txrdy_q;
      status[SB_TXEMT]                = txemt_q;
      status[STAT_W-1:SB_ERR_LO]      = err_q;
   end

   assign rx_en     = rx_en_q;
   assign tx_rdy    = txrdy_q;
   assign irq_txrdy = irq_tx_q;
   assign irq_rxrdy = rxrdy_q;
   assign irq_brk   = brk_irq_q;

   AST_RX_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.rx_off |=> !rx_en); // R1
   AST_TX_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.tx_on && !ctl.tx_off && !ctl.tx_rst) |=>
         (status[SB_TXRDY] && status[SB_TXEMT] && irq_txrdy)); // R2
   AST_TX_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.tx_rst |=> (!status[SB_TXRDY] && !status[SB_TXEMT] && !irq_txrdy)); // R3
   AST_RX_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.rx_rst |=> (!rx_en && !status[SB_RXRDY] && !status[SB_FFULL] && !irq_rxrdy)); // R4
   AST_ERR_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.err_clr && err_evt == '0) |=> (status[STAT_W-1:SB_ERR_LO] == '0)); // R5
   AST_BRK_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.brk_clr && !err_evt[N_ERR-1]) |=> !irq_brk); // R6
endmodule

// File: rtl/chctl_tx_path.sv
module chctl_tx_path #(
   parameter int DW     = 8,
   parameter bit TX_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_wr,
   input  logic [DW-1:0] wdata,
   input  logic          tx_rdy,
   output logic          tx_valid,
   output logic [DW-1:0] tx_data
);
   logic accept;
   assign accept = hold_wr && tx_rdy;

   generate
      if (TX_REG) begin : g_reg
         logic          vld_q;
         logic [DW-1:0] dat_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               dat_q <= '0;
            end else begin
               vld_q <= accept;
               if (accept)
                  dat_q <= wdata;
            end
         end
         assign tx_valid = vld_q;
         assign tx_data  = dat_q;

         AST_TX_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid |-> $past(tx_rdy)); // R8
      end else begin : g_comb
         assign tx_valid = accept;
         assign tx_data  = wdata;
      end
   endgenerate
endmodule

// File: rtl/uart_chctl.sv
module uart_chctl
   import uart_chctl_pkg::*;
#(
   parameter int DW      = 8,
   parameter int AW      = 2,
   parameter int N_MODE  = 2,
   parameter bit TX_REG  = 1'b1,
   parameter int A_MODE  = 0,
   parameter int A_STAT  = 1,
   parameter int A_CMD   = 2,
   parameter int A_HOLD  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          rx_nonempty,
   input  logic          rx_full,
   input  logic [3:0]    err_evt,
   output logic          rx_en,
   output logic          fifo_flush,
   output logic          tx_valid,
   output logic [DW-1:0] tx_data,
   output logic          irq_txrdy,
   output logic          irq_rxrdy,
   output logic          irq_brk
);
   localparam logic [AW-1:0] AD_MODE = AW'(A_MODE);
   localparam logic [AW-1:0] AD_STAT = AW'(A_STAT);
   localparam logic [AW-1:0] AD_CMD  = AW'(A_CMD);
   localparam logic [AW-1:0] AD_HOLD = AW'(A_HOLD);

   generate
      if (DW < STAT_W) begin : g_bad_dw
         $error("uart_chctl data width must hold the status byte");
      end
      if (AW < 2) begin : g_bad_aw
         $error("uart_chctl needs at least two address bits");
      end
   endgenerate

   logic              sel_mode, sel_cmd, sel_hold;
   chctl_cmd_t        ctl;
   logic [DW-1:0]     mode_rdata;
   logic [STAT_W-1:0] status;
   logic              tx_rdy;

   assign sel_mode = (bus_addr == AD_MODE);
   assign sel_cmd  = (bus_addr == AD_CMD);
   assign sel_hold = (bus_addr == AD_HOLD);

   chctl_cmd_decode #(.DW(DW)) u_dec (
      .cmd_wr   (bus_wr && sel_cmd),
      .cmd_byte (bus_wdata),
      .ctl      (ctl)
   );

   chctl_mode_regs #(.DW(DW), .N_MODE(N_MODE)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_rd  (bus_rd && sel_mode),
      .acc_wr  (bus_wr && sel_mode),
      .wdata   (bus_wdata),
      .ptr_clr (ctl.ptr_clr),
      .rdata   (mode_rdata)
   );

   chctl_status_core u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl         (ctl),
      .rx_nonempty (rx_nonempty),
      .rx_full     (rx_full),
      .err_evt     (err_evt),
      .status      (status),
      .rx_en       (rx_en),
      .tx_rdy      (tx_rdy),
      .irq_txrdy   (irq_txrdy),
      .irq_rxrdy   (irq_rxrdy),
      .irq_brk     (irq_brk)
   );

   chctl_tx_path #(.DW(DW), .TX_REG(TX_REG)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_wr  (bus_wr && sel_hold),
      .wdata    (bus_wdata),
      .tx_rdy   (tx_rdy),
      .tx_valid (tx_valid),
      .tx_data  (tx_data)
   );

   assign fifo_flush = ctl.rx_rst;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AD_MODE)
         bus_rdata = mode_rdata;
      else if (bus_addr == AD_STAT)
         bus_rdata = DW'(status);
   end
endmodule

// File: tb/uart_chctl_tb.sv
module uart_chctl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rx_nonempty = 1'b0, rx_full = 1'b0;
   logic [3:0] err_evt = '0;
   logic       rx_en, fifo_flush, tx_valid, irq_txrdy, irq_rxrdy, irq_brk;
   logic [7:0] tx_data;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   uart_chctl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_nonempty(rx_nonempty), .rx_full(rx_full), .err_evt(err_evt),
      .rx_en(rx_en), .fifo_flush(fifo_flush), .tx_valid(tx_valid),
      .tx_data(tx_data), .irq_txrdy(irq_txrdy), .irq_rxrdy(irq_rxrdy),
      .irq_brk(irq_brk)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 chk(bus_rdata, exp, tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic send(input logic [7:0] d);
      exp_q.push_back(d);
      wr(2'd3, d);
   endtask

   // monitor: compare each transmitted byte against the scoreboard
   always @(negedge clk) begin
      if (rst_n && tx_valid) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R8: actual=%h expected=no byte", tx_data);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (tx_data !== e) begin
               bad++;
               $display("FAIL R8: actual=%h expected=%h", tx_data, e);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(rx_en, 0, "R9 rx_en");
      chk({irq_txrdy, irq_rxrdy, irq_brk}, 0, "R9 irq flags");
      rd(2'd1, 8'h00, "R9 status after reset");

      // R7 mode pointer
      wr(2'd0, 8'h13);
      wr(2'd0, 8'h07);
      wr(2'd0, 8'h55);
      wr(2'd2, 8'h10);
      rd(2'd0, 8'h13, "R7 first mode reg");
      rd(2'd0, 8'h55, "R7 second mode reg");
      rd(2'd0, 8'h55, "R7 pointer sticks");

      // R8 drop while not ready
      wr(2'd3, 8'hA5);
      rd(2'd1, 8'h00, "R8 status after dropped write");

      // R2 transmitter enable
      wr(2'd2, 8'h04);
      rd(2'd1, 8'h0C, "R2 tx enable status");
      chk(irq_txrdy, 1, "R2 irq_txrdy set");

      // R8 forwarded bytes
      send(8'h3C);
      send(8'hC3);
      rd(2'd1, 8'h0C, "R8 TXRDY kept");

      // R1 receiver enable/disable
      wr(2'd2, 8'h01);
      chk(rx_en, 1, "R1 enable");
      wr(2'd2, 8'h03);
      chk(rx_en, 0, "R1 disable wins");
      wr(2'd2, 8'h01);
      chk(rx_en, 1, "R1 re-enable");

      // R2 disable wins, R3 transmitter reset beats enable bit
      wr(2'd2, 8'h0C);
      rd(2'd1, 8'h00, "R2 disable wins status");
      chk(irq_txrdy, 0, "R2 irq_txrdy cleared");
      wr(2'd2, 8'h04);
      wr(2'd2, 8'h34);
      rd(2'd1, 8'h00, "R3 tx reset with enable");
      chk(irq_txrdy, 0, "R3 irq_txrdy after reset");
      wr(2'd2, 8'h04);

      // R10 FIFO status mirror
      @(negedge clk);
      rx_nonempty = 1'b1; rx_full = 1'b1;
      rd(2'd1, 8'h0F, "R10 rxrdy and ffull");
      chk(irq_rxrdy, 1, "R10 irq_rxrdy");

      // R4 receiver reset with enable bit
      @(negedge clk);
      bus_addr = 2'd2; bus_wdata = 8'h21; bus_wr = 1'b1;
      #1 chk(fifo_flush, 1, "R4 flush pulse");
      @(negedge clk);
      bus_wr = 1'b0;
      rx_nonempty = 1'b0; rx_full = 1'b0;
      chk(rx_en, 0, "R4 receiver off");
      chk(irq_rxrdy, 0, "R4 irq_rxrdy cleared");
      rd(2'd1, 8'h0C, "R4 status after rx reset");
      chk(fifo_flush, 0, "R4 flush idle");

      // R5 error flags
      @(negedge clk);
      err_evt = 4'hF;
      @(negedge clk);
      err_evt = 4'h0;
      rd(2'd1, 8'hFC, "R5 errors set");
      chk(irq_brk, 1, "R6 break irq raised");
      wr(2'd2, 8'h40);
      rd(2'd1, 8'h0C, "R5 errors cleared");
      chk(irq_brk, 1, "R5 irq_brk untouched");

      // R6 break interrupt
      wr(2'd2, 8'h50);
      chk(irq_brk, 0, "R6 break irq cleared");
      @(negedge clk);
      err_evt = 4'h8;
      @(negedge clk);
      err_evt = 4'h0;
      chk(irq_brk, 1, "R6 new break raises");
      wr(2'd2, 8'h50);
      rd(2'd1, 8'h8C, "R6 clear keeps status");
      @(negedge clk);
      err_evt = 4'h8;
      @(negedge clk);
      err_evt = 4'h0;
      chk(irq_brk, 0, "R6 repeated break no irq");
      wr(2'd2, 8'h40);

      // R3 ignored codes, R9 status-address write ignored
      wr(2'd2, 8'h01);
      for (int k = 6; k < 16; k++) begin
         if (k != 11) wr(2'd2, 8'(k << 4));
      end
      wr(2'd1, 8'hFF);
      chk(rx_en, 1, "R3 ignored codes keep rx_en");
      chk({irq_txrdy, irq_rxrdy, irq_brk}, 3'b100, "R3 ignored codes keep flags");
      rd(2'd1, 8'h0C, "R9 status write ignored");
      rd(2'd0, 8'h55, "R3 ignored codes keep pointer");

      send(8'h81);
      repeat (3) @(negedge clk);
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R8: actual=%0d pending expected=0", exp_q.size());
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule